// File: doc/BRIEF.md
# Programmable Input Noise Filter

This block cleans up one external interrupt input before it reaches an interrupt controller. The raw pin is first brought into the system clock domain. It is then sampled on a slow tick produced by a divider whose ratio software selects. A new level reaches the output only after it has been seen on three sampling ticks in a row. A change that does not last that long is thrown away as noise. The filtered level is registered. Its rising and falling transitions are also reported as one-cycle strobes.

An 8-bit control register sets the behaviour. It holds an enable bit and a 3-bit divider code, and software always reads or writes it as a full byte. When the enable bit is clear, the filter is bypassed and the synchronized pin drives the output directly. While bypassed, the filter keeps its sample history equal to the live input, so turning filtering on does not produce a false edge.

Top module: `pin_glitch_filter`

## Requirements
- R1: The pin passes through two synchronizing flops on the system clock before any other use. In bypass mode, a pin change driven before clock edge 0 appears on `level_o` after edge 2, which is the third rising edge.
- R2: With filtering enabled, `level_o` changes only on the clock edge of a sampling tick, and only when the current sample and the two preceding tick samples all equal the new level. An input level seen on fewer than three consecutive ticks never reaches `level_o`.
- R3: With filtering enabled, a synchronized level held for at least three full sampling periods is always accepted.
- R4: Divider codes 0, 1, 2, 3, 4 and 5 place 4, 16, 64, 128, 256 and 512 system clocks between sampling ticks. After an accepted write with the pin already changed, the rising strobe is seen right after clock edge 3×divisor, counting the write edge as edge 0.
- R5: Register layout: bit 7 is the enable bit and bits 2:0 are the divider code. `reg_rdata_o` always shows the stored value, and bits 6:3 always read 0.
- R6: Reset (synchronous, `rst_n` low) sets the register to 00H, which means bypass and divide-by-4. It also drives `level_o`, `rise_o` and `fall_o` low.
- R7: A write whose code field is 6 or 7 leaves the stored divider code unchanged. The enable bit of that write still takes effect.
- R8: A write with a valid code restarts the divider from zero on the write edge, so the next tick comes exactly one full divisor of clocks later.
- R9: With the enable bit at 0, `level_o` equals the synchronized input one clock later, with no filtering.
- R10: `rise_o` or `fall_o` is high for exactly the one cycle in which `level_o` first shows its new high or low value. The two are never high together.
- R11: While bypassed, the filter history follows the input. Setting the enable bit therefore causes no strobe and no change of `level_o` while the input holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous external input |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| level_o | output | 1 | Filtered input level |
| rise_o | output | 1 | One-cycle strobe on a low-to-high change of level_o |
| fall_o | output | 1 | One-cycle strobe on a high-to-low change of level_o |

## Verification
The filter is driven with pulses shorter than two sampling periods and pulses of exactly three sampling periods. These show that brief glitches are rejected and that minimum-length levels are accepted. For every divider code, a write combined with a pin step measures the latency down to the exact cycle. This separates the six divide ratios and confirms the divider restart on write. Bypass steps, reserved-code writes and enabling while the input sits high each isolate one register or mode rule. Long stretches of random pin toggling at several divide ratios, compared every clock against a behavioural model, cover the cases where noise lands near tick boundaries.

// File: rtl/glf_pkg.sv
// Package: shared constants, control register type and divider decode for
// the programmable input noise filter. Assumes divisors are powers of two.
package glf_pkg;

    localparam int CTRL_W    = 8;
    localparam int EN_BIT    = 7;
    localparam int SEL_W     = 3;
    localparam int NUM_CODES = 6;
    localparam int MAX_SHIFT = 9;
    localparam int CNT_W     = MAX_SHIFT;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    // Report whether a divider code is one of the supported ones.
    function automatic logic code_ok(input logic [SEL_W-1:0] code);
        return (int'(code) < NUM_CODES);
    endfunction

    // Return the terminal count (divisor minus one) for a divider code.
    function automatic logic [CNT_W-1:0] div_last(input logic [SEL_W-1:0] code);
        int sh;
        case (code)
            3'd0:    sh = 2;
            3'd1:    sh = 4;
            3'd2:    sh = 6;
            3'd3:    sh = 7;
            3'd4:    sh = 8;
            default: sh = MAX_SHIFT;
        endcase
        return CNT_W'((1 << sh) - 1);
    endfunction

endpackage

// File: rtl/glf_sync.sv
// Module: glf_sync
// Brings an asynchronous input into the clock domain through a chain of
// flops. Assumes STAGES >= 2. Resets to zero.
module glf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchronizing chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/glf_ctrl.sv
// Module: glf_ctrl
// Byte-wide control register. It holds the enable bit and the divider code.
// A reserved code leaves the stored code untouched. An accepted code raises
// sel_load_o in the write cycle so that the divider can restart.
module glf_ctrl
    import glf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic              sel_load_o,
    output logic [CTRL_W-1:0] rdata_o
);

    ctrl_t            ctrl_q;
    logic [SEL_W-1:0] wcode;
    logic             unused_wbits;

    assign wcode        = wdata_i[SEL_W-1:0];
    assign unused_wbits = ^wdata_i[EN_BIT-1:SEL_W];
    assign sel_load_o   = wr_i && code_ok(wcode);

    // Store the enable bit on any write and the code only when it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q.en <= wdata_i[EN_BIT];
            if (code_ok(wcode)) ctrl_q.sel <= wcode;
        end
    end

    // Assemble the read value; bits that are not used read as zero.
    always_comb begin
        rdata_o                = '0;
        rdata_o[EN_BIT]        = ctrl_q.en;
        rdata_o[SEL_W-1:0]     = ctrl_q.sel;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/glf_prescaler.sv
// Module: glf_prescaler
// Free-running divider that produces a one-clock sampling tick once every
// divisor clocks. It restarts from zero when restart_i is high.
module glf_prescaler
    import glf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             restart_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last   = div_last(sel_i);
    assign tick_o = (cnt == last);

    // Count up to the terminal value, wrap, or restart on a code write.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart_i)      cnt <= '0;
        else if (tick_o)         cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/glf_core.sv
// Module: glf_core
// Majority-free voting filter. On each tick it takes a sample, and it
// accepts a new level only when the last VOTES samples agree. When bypassed,
// the output and the history follow the input every clock.
module glf_core #(
    parameter int VOTES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic sample_i,
    output logic level_o
);

    localparam int HIST_W = VOTES - 1;

    logic [HIST_W-1:0] hist;
    logic [VOTES-1:0]  window;
    logic              filt_q;
    logic              all_high;
    logic              all_low;

    assign window   = {hist, sample_i};
    assign all_high = &window;
    assign all_low  = ~|window;

    // Keep the sample history: follow the input when bypassed, else shift on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      hist <= '0;
        else if (!en_i)  hist <= {HIST_W{sample_i}};
        else if (tick_i) hist <= window[HIST_W-1:0];
    end

    // Update the output level: pass through when bypassed, else vote on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                   filt_q <= 1'b0;
        else if (!en_i)               filt_q <= sample_i;
        else if (tick_i && all_high)  filt_q <= 1'b1;
        else if (tick_i && all_low)   filt_q <= 1'b0;
    end

    assign level_o = filt_q;

endmodule

// File: rtl/pin_glitch_filter.sv
// Module: pin_glitch_filter (top)
// Programmable digital noise filter for one interrupt input. It contains
// the synchronizer, the control register, the prescaler and the voting core,
// and it produces the filtered level plus edge strobes. Assumes a single clock.
module pin_glitch_filter
    import glf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VOTES       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic              reg_wr_i,
    input  logic [CTRL_W-1:0] reg_wdata_i,
    output logic [CTRL_W-1:0] reg_rdata_o,
    output logic              level_o,
    output logic              rise_o,
    output logic              fall_o
);

    ctrl_t ctrl;
    logic  sel_load;
    logic  sync_lvl;
    logic  presc_tick;
    logic  level;
    logic  level_d;

    glf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_lvl)
    );

    glf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i),
        .ctrl_o     (ctrl),
        .sel_load_o (sel_load),
        .rdata_o    (reg_rdata_o)
    );

    glf_prescaler u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (ctrl.sel),
        .restart_i (sel_load),
        .tick_o    (presc_tick)
    );

    glf_core #(.VOTES(VOTES)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctrl.en),
        .tick_i   (presc_tick),
        .sample_i (sync_lvl),
        .level_o  (level)
    );

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign level_o = level;
    assign rise_o  = level & ~level_d;
    assign fall_o  = ~level & level_d;

endmodule

// File: rtl/glf_checker.sv
// Module: glf_checker
// Property checks for pin_glitch_filter, attached with bind. It watches the
// ports together with the internal tick and the synchronized level.
module glf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       level_o,
    input logic       rise_o,
    input logic       fall_o,
    input logic       tick,
    input logic       sync_lvl
);

    logic seen = 1'b0;

    // Mark that at least one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        seen <= rst_n;
    end

    assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        reg_rdata_o[6:3] == 4'b0000);

    assert_reserved_keep_R7: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (reg_wr_i && reg_wdata_i[2:0] > 3'd5) |=>
            (reg_rdata_o[2:0] == $past(reg_rdata_o[2:0]) && reg_rdata_o[7] == $past(reg_wdata_i[7])));

    assert_restart_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (reg_wr_i && reg_wdata_i[2:0] <= 3'd5) |=> !tick);

    assert_bypass_follow_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !reg_rdata_o[7] |=> (level_o == $past(sync_lvl)));

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (reg_rdata_o[7] && !tick) |=> $stable(level_o));

    assert_rise_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        rise_o == (level_o && !$past(level_o)));

    assert_fall_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        fall_o == (!level_o && $past(level_o)));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !(rise_o && fall_o));

endmodule

bind pin_glitch_filter glf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .level_o     (level_o),
    .rise_o      (rise_o),
    .fall_o      (fall_o),
    .tick        (presc_tick),
    .sync_lvl    (sync_lvl)
);

// File: tb/sim_pin_glitch_filter.sv
// Bench for pin_glitch_filter: a behavioural reference model is compared
// on every clock, and directed checks cover latency and corner cases.
module sim_pin_glitch_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       level, rise, fall;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pin_glitch_filter u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .level_o     (level),
        .rise_o      (rise),
        .fall_o      (fall)
    );

    // Record one check and report any mismatch.
    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int divisor(input int code);
        case (code)
            0: return 4;
            1: return 16;
            2: return 64;
            3: return 128;
            4: return 256;
            default: return 512;
        endcase
    endfunction

    // Behavioural reference model state.
    int m_s1, m_s2, m_en, m_sel, m_cnt, m_filt, m_prev;
    int m_q[$];

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_en = 0; m_sel = 0; m_cnt = 0;
            m_filt = 0; m_prev = 0; m_q = '{0, 0, 0};
        end else begin
            int  d;
            bit  tk;
            bit  ok_code;
            d = divisor(m_sel);
            tk = (m_cnt == d - 1);
            ok_code = wr && (wdata[2:0] <= 3'd5);
            m_prev = m_filt;
            if (m_en == 0) begin
                m_filt = m_s2;
                m_q = '{m_s2, m_s2, m_s2};
            end else if (tk) begin
                m_q.push_back(m_s2);
                void'(m_q.pop_front());
                if (m_q[0] == m_q[1] && m_q[1] == m_q[2]) m_filt = m_q[0];
            end
            if (ok_code) m_cnt = 0;
            else if (tk) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            m_s2 = m_s1;
            m_s1 = int'(pin);
            if (wr) begin
                m_en = int'(wdata[7]);
                if (ok_code) m_sel = int'(wdata[2:0]);
            end
        end
    end

    // Compare outputs to the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 R3 R9 level_o vs model", int'(level), m_filt);
            chk("R10 rise_o vs model", int'(rise), int'(m_filt == 1 && m_prev == 0));
            chk("R10 fall_o vs model", int'(fall), int'(m_filt == 0 && m_prev == 1));
            chk("R5 R7 reg_rdata_o vs model", int'(rdata), (m_en << 7) | m_sel);
        end
    end

    task automatic reg_write(input logic [7:0] v);
        wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count edge strobes over a window of clocks.
    task automatic count_strobes(input int n, output int r, output int f);
        r = 0; f = 0;
        repeat (n) begin
            @(negedge clk);
            r += int'(rise);
            f += int'(fall);
        end
    endtask

    initial begin
        int r, f, k;
        wait_n(4);
        rst_n = 1'b1;
        // R6: reset state
        chk("R6 reset rdata", int'(rdata), 0);
        chk("R6 reset level_o", int'(level), 0);
        chk("R6 reset strobes", int'(rise) + int'(fall), 0);

        // R1 bypass latency through synchronizer
        wait_n(4);
        pin = 1'b1;
        k = 0;
        while (!level && k < 20) begin
            @(posedge clk); k++; @(negedge clk);
        end
        chk("R1 R9 bypass latency edges", k, 3);
        pin = 1'b0;
        wait_n(6);

        // R5/R7 register behaviour
        reg_write(8'h81);
        chk("R5 write 81h readback", int'(rdata), 8'h81);
        reg_write(8'h86);
        chk("R7 reserved code 6 keeps select", int'(rdata), 8'h81);
        reg_write(8'h07);
        chk("R7 reserved code 7 keeps select, clears enable", int'(rdata), 8'h01);
        reg_write(8'h7B);
        chk("R5 bits 6:3 read zero", int'(rdata), 8'h03);

        // R2/R3 pulse widths at divide-by-4
        reg_write(8'h80);
        wait_n(20);
        pin = 1'b1; wait_n(7); pin = 1'b0;
        count_strobes(40, r, f);
        chk("R2 short pulse rejected rises", r, 0);
        chk("R2 short pulse level stays low", int'(level), 0);
        pin = 1'b1; wait_n(12); pin = 1'b0;
        count_strobes(40, r, f);
        chk("R3 three-period pulse accepted rises", r, 1);
        chk("R3 three-period pulse then falls", f, 1);

        // R11 enabling while input high gives no edge
        reg_write(8'h00);
        pin = 1'b1;
        wait_n(10);
        chk("R9 bypass level high", int'(level), 1);
        reg_write(8'h80);
        count_strobes(40, r, f);
        chk("R11 no strobe on enable", r + f, 0);
        chk("R11 level kept on enable", int'(level), 1);
        pin = 1'b0;

        // R4/R8 latency for every divider code
        for (int c = 0; c < 6; c++) begin
            reg_write(8'h00);
            wait_n(8);
            pin = 1'b1; wr = 1'b1; wdata = 8'h80 | 8'(c);
            @(posedge clk);
            @(negedge clk);
            wr = 1'b0;
            k = 0;
            while (!rise && k < 4000) begin
                @(posedge clk); k++; @(negedge clk);
            end
            chk($sformatf("R4 R8 code %0d rise edge", c), k, 3 * divisor(c));
            pin = 1'b0;
        end

        // Random noise at several rates, checked by the model every clock
        for (int c = 0; c < 3; c++) begin
            reg_write(8'h80 | 8'(c));
            for (int i = 0; i < 300; i++) begin
                pin = 1'($urandom_range(0, 1));
                wait_n(int'($urandom_range(1, 7 * divisor(c))));
                if (n_cmp > 400000) break;
            end
        end

        wait_n(4);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule